// File: doc/BRIEF.md
# Held-Select Control Decompressor

This block turns a compressed control stream into one select bit per scan chain. Each select bit decides whether its chain takes the shared parent data or the sparse incremental data. A linear ring generator absorbs the tester channel bits on every shift cycle. The select outputs do not come from the generator directly. They come through a phase shifter fed by a shadow copy of the generator, so one generator state can steer the selects for a long run of shift cycles while the generator itself keeps collecting fresh variables for the next run.

The shadow copy has no dedicated load pin. It reloads when the parity of the channel bits is 1. That parity covers the bits presented in the current cycle and those injected in the last `BUF_DEPTH` shifting cycles, which small per-channel history buffers keep. An external solver picks channel values so that this parity rises exactly where a new select run must begin. The same channel values also carry the generator variables.

Top module: `ctl_hold_decomp`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears the generator, the channel history and the shadow copy to zero, so `sel_out` is all zeros on the cycle after that edge.
- R2: On a rising edge with `shift_en` high and a reload parity of 1, the shadow copy takes the generator state from before that edge, not the state the generator advances to at that edge.
- R3: On a rising edge with `shift_en` high and a reload parity of 0, the shadow copy, and with it `sel_out`, keeps its value.
- R4: The generator advances on every edge with `shift_en` high, whether or not the shadow copy reloads.
- R5: The reload parity is the XOR of all `CHANNELS` bits of `chan_in` in the current cycle and of all channel bits injected in the previous `BUF_DEPTH` shifting cycles (default: 2 channels, depth 1, so the parity is a_k ^ b_k ^ a_(k-1) ^ b_(k-1)).
- R6: Cycles with `shift_en` low do not enter the channel history, so the next shifting cycle computes its parity from the last injected bits.
- R7: With `shift_en` low, the generator and the shadow copy hold, whatever `chan_in` carries.
- R8: `sel_out[j]` is the XOR of shadow bits (3j) mod L, (3j+5) mod L and (3j+11) mod L, where L is `RING_LEN` (16 by default), and it depends on the shadow copy alone.
- R9: One shift step of the generator: the next state is the current state shifted one place toward the MSB with 0 into bit 0, XORed with `FB_MASK` (default 16'h6801) when the old MSB is 1, then XORed with channel c's bit at position c*L/`CHANNELS` (bits 0 and 8 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Synchronous reset, active low |
| shift_en | input | 1 | High on cycles that shift the scan chains |
| chan_in | input | CHANNELS | Tester channel bits for this shift cycle |
| sel_out | output | CHAINS | Per-chain source select |

## Verification
The bench aims at the reload timing: a design that copied the advanced generator state instead of the pre-edge one would show the select pattern of the next state, one step early. It injects a single channel bit and then zeros, so that only the buffered history can raise the parity; a design that left out the buffer or shifted it on idle cycles would miss that reload or fire it at the wrong cycle. Both channels driven high together cancel in the parity and must leave the selects frozen. Long idle gaps with noisy channel bits, and a reset in mid-stream, catch a generator that drifts while not shifting or a history that survives reset.

// File: rtl/chd_pkg.sv
package chd_pkg;

    // Index of one phase-shifter tap for a given chain.
    function automatic int ps_index(input int chain, input int stride,
                                    input int offset, input int len);
        return (chain * stride + offset) % len;
    endfunction

    // Ring bit that receives a given tester channel.
    function automatic int inj_index(input int chan, input int spacing);
        return chan * spacing;
    endfunction

endpackage

// File: rtl/chd_ring.sv
module chd_ring #(
    parameter int              RING_LEN = 16,
    parameter int              CHANNELS = 2,
    parameter logic [RING_LEN-1:0] FB_MASK = 16'h6801
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic [CHANNELS-1:0] chan_in,
    output logic [RING_LEN-1:0] ring_q
);
    import chd_pkg::*;

    localparam int SPACING = RING_LEN / CHANNELS;

    typedef struct packed {
        logic [RING_LEN-1:0] ring;
    } ring_state_t;

    ring_state_t st_d, st_q;
    logic [RING_LEN-1:0] inj_vec;

    always_comb begin
        inj_vec = '0;
        for (int c = 0; c < CHANNELS; c++) begin
            inj_vec[inj_index(c, SPACING)] = chan_in[c];
        end
        st_d = st_q;
        if (shift_en) begin
            st_d.ring = {st_q.ring[RING_LEN-2:0], 1'b0}
                      ^ (st_q.ring[RING_LEN-1] ? FB_MASK : '0)
                      ^ inj_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ring_q = st_q.ring;
endmodule

// File: rtl/chd_parity.sv
module chd_parity #(
    parameter int CHANNELS  = 2,
    parameter int BUF_DEPTH = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic [CHANNELS-1:0] chan_in,
    output logic                load_en
);
    typedef struct packed {
        logic [BUF_DEPTH-1:0][CHANNELS-1:0] hist;
    } hist_state_t;

    hist_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.hist[0] = chan_in;
            for (int i = 1; i < BUF_DEPTH; i++) begin
                st_d.hist[i] = st_q.hist[i-1];
            end
        end
        load_en = (^chan_in) ^ (^st_q.hist);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/chd_shadow.sv
module chd_shadow #(
    parameter int RING_LEN = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic                load_en,
    input  logic [RING_LEN-1:0] ring_q,
    output logic [RING_LEN-1:0] shadow_q
);
    typedef struct packed {
        logic [RING_LEN-1:0] shadow;
    } shadow_state_t;

    shadow_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en && load_en) begin
            st_d.shadow = ring_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shadow_q = st_q.shadow;
endmodule

// File: rtl/chd_phase.sv
module chd_phase #(
    parameter int RING_LEN  = 16,
    parameter int CHAINS    = 8,
    parameter int PS_STRIDE = 3,
    parameter int PS_OFF_B  = 5,
    parameter int PS_OFF_C  = 11
) (
    input  logic [RING_LEN-1:0] shadow_q,
    output logic [CHAINS-1:0]   sel_out
);
    import chd_pkg::*;

    for (genvar j = 0; j < CHAINS; j++) begin : g_chain
        localparam int TAP_A = ps_index(j, PS_STRIDE, 0,        RING_LEN);
        localparam int TAP_B = ps_index(j, PS_STRIDE, PS_OFF_B, RING_LEN);
        localparam int TAP_C = ps_index(j, PS_STRIDE, PS_OFF_C, RING_LEN);
        assign sel_out[j] = shadow_q[TAP_A] ^ shadow_q[TAP_B] ^ shadow_q[TAP_C];
    end
endmodule

// File: rtl/ctl_hold_decomp.sv
module ctl_hold_decomp #(
    parameter int                  RING_LEN  = 16,
    parameter int                  CHANNELS  = 2,
    parameter int                  BUF_DEPTH = 1,
    parameter int                  CHAINS    = 8,
    parameter logic [RING_LEN-1:0] FB_MASK   = 16'h6801
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic [CHANNELS-1:0] chan_in,
    output logic [CHAINS-1:0]   sel_out
);
    logic [RING_LEN-1:0] ring_q;
    logic [RING_LEN-1:0] shadow_q;
    logic                load_en;

    chd_ring #(
        .RING_LEN (RING_LEN),
        .CHANNELS (CHANNELS),
        .FB_MASK  (FB_MASK)
    ) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .chan_in  (chan_in),
        .ring_q   (ring_q)
    );

    chd_parity #(
        .CHANNELS  (CHANNELS),
        .BUF_DEPTH (BUF_DEPTH)
    ) u_parity (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .chan_in  (chan_in),
        .load_en  (load_en)
    );

    chd_shadow #(
        .RING_LEN (RING_LEN)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .load_en  (load_en),
        .ring_q   (ring_q),
        .shadow_q (shadow_q)
    );

    chd_phase #(
        .RING_LEN (RING_LEN),
        .CHAINS   (CHAINS)
    ) u_phase (
        .shadow_q (shadow_q),
        .sel_out  (sel_out)
    );
endmodule

// File: rtl/ctl_hold_decomp_chk.sv
module ctl_hold_decomp_chk #(
    parameter int RING_LEN = 16,
    parameter int CHAINS   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                shift_en,
    input logic                load_en,
    input logic [RING_LEN-1:0] ring_q,
    input logic [RING_LEN-1:0] shadow_q,
    input logic [CHAINS-1:0]   sel_out
);
    logic rst_seen_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
        if (rst_seen_q === 1'b1) begin
            p_reset_clear_r1: assert (ring_q == '0 && shadow_q == '0 && sel_out == '0)
                else $error("reset did not clear state");
        end
    end

    p_capture_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && load_en) |=> (shadow_q == $past(ring_q)));

    p_hold_shadow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_en && load_en) |=> $stable(shadow_q));

    p_ring_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(ring_q));

    p_sel_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(shadow_q) |-> $stable(sel_out));
endmodule

bind ctl_hold_decomp ctl_hold_decomp_chk #(
    .RING_LEN (RING_LEN),
    .CHAINS   (CHAINS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .load_en  (load_en),
    .ring_q   (ring_q),
    .shadow_q (shadow_q),
    .sel_out  (sel_out)
);

// File: tb/tb_ctl_hold_decomp.sv
`timescale 1ns/1ps
module tb_ctl_hold_decomp;
    localparam int L   = 16;
    localparam int NCH = 2;
    localparam int BD  = 1;
    localparam int NS  = 8;
    localparam logic [L-1:0] FBM = 16'h6801;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shift_en = 1'b0;
    logic [NCH-1:0] chan_in = '0;
    logic [NS-1:0] sel_out;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [NS-1:0] q_exp[$];
    string         q_tag[$];

    logic [L-1:0] m_ring = '0;
    logic [L-1:0] m_shadow = '0;
    logic [BD-1:0][NCH-1:0] m_hist = '0;

    always #2.5 clk = ~clk;

    ctl_hold_decomp dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .chan_in  (chan_in),
        .sel_out  (sel_out)
    );

    // R8 model of the output taps
    function automatic logic [NS-1:0] sel_of(input logic [L-1:0] sh);
        logic [NS-1:0] s;
        for (int j = 0; j < NS; j++)
            s[j] = sh[(3*j) % L] ^ sh[(3*j+5) % L] ^ sh[(3*j+11) % L];
        return s;
    endfunction

    // R9 model of one generator step
    function automatic logic [L-1:0] adv(input logic [L-1:0] r, input logic [NCH-1:0] ch);
        logic [L-1:0] n;
        n = {r[L-2:0], 1'b0} ^ (r[L-1] ? FBM : '0);
        for (int c = 0; c < NCH; c++) n[c * (L / NCH)] ^= ch[c];
        return n;
    endfunction

    // Driver: applies one cycle and queues the select value expected after its edge
    task automatic step(input bit rst, input bit en, input logic [NCH-1:0] ch, input string tag);
        logic ld;
        @(negedge clk);
        rst_n = !rst;
        shift_en = en;
        chan_in = ch;
        if (rst) begin
            m_ring = '0; m_shadow = '0; m_hist = '0;
        end else if (en) begin
            ld = (^ch) ^ (^m_hist);           // R5 parity
            if (ld) m_shadow = m_ring;        // R2 pre-edge capture
            m_ring = adv(m_ring, ch);         // R4 always advances
            for (int i = BD - 1; i > 0; i--) m_hist[i] = m_hist[i-1];
            m_hist[0] = ch;                   // R6 history only on shift
        end
        q_exp.push_back(sel_of(m_shadow));
        q_tag.push_back(tag);
    endtask

    // Monitor: compares after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_exp.size() > 0) begin
                logic [NS-1:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                checks++;
                if (sel_out !== e) begin
                    fails++;
                    $display("FAIL %s: sel_out actual %h expected %h", t, sel_out, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) step(1, 0, '0, "R1");
        // R3: zero channels never reload, selects stay at zero
        repeat (5) step(0, 1, 2'b00, "R3");
        // R5: a single bit, then zeros; only the history raises the second parity
        step(0, 1, 2'b01, "R5");
        step(0, 1, 2'b00, "R5");   // captures ring 0x0001 -> sel 8'h81
        step(0, 1, 2'b00, "R3");
        // R5: both channels high cancel in the current-cycle parity
        step(0, 1, 2'b11, "R5");
        step(0, 1, 2'b11, "R5");
        step(0, 1, 2'b00, "R5");
        // R2 R4 R9: mixed traffic
        for (int k = 0; k < 1500; k++)
            step(0, 1, 2'($urandom), "R2 R4 R9");
        // R6 R7: idle gaps with noisy channels, then resume
        for (int k = 0; k < 40; k++) begin
            int gap;
            gap = int'($urandom % 6);
            for (int g = 0; g < gap; g++) step(0, 0, 2'($urandom), "R7");
            step(0, 1, 2'($urandom), "R6");
        end
        // R1: reset mid-stream, then R8 over fresh traffic
        step(1, 1, 2'b11, "R1");
        step(0, 1, 2'b10, "R1");
        for (int k = 0; k < 500; k++)
            step(0, ($urandom % 4) != 0, 2'($urandom), "R8");
        step(0, 0, 2'b00, "R7");
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule